// File: doc/BRIEF.md
# One-Bit Control Processor Core

This block is the execution core of a bit-serial controller for relay-style logic. Each clock cycle it takes one 4-bit instruction and a single data bit. It updates a one-bit accumulator and two one-bit gate registers, and it may drive the data line. It also raises at most one single-cycle strobe, which the surrounding system uses to write to an output latch, to control its program counter, or as a general flag. The program counter, the program memory and the I/O address decoding all sit outside this block.

The bidirectional data line is split into three signals: `data_in`, `data_out` and the drive enable `data_oe`. An input gate register masks every operand that the logic instructions read. An output gate register decides whether a store produces a write strobe. Two instructions can cancel the instruction that follows them: the return instruction always does, and the skip-if-zero instruction does when the accumulator holds 0. The core keeps this condition in an internal skip register.

Top module: `bitproc_core`

## Requirements
- R1: While `rst_n` is low, the accumulator, the input gate, the output gate and the skip register all clear to 0. After reset, a store produces no write strobe and a load of 1 leaves the accumulator at 0.
- R2: The operand of every logic instruction (opcodes 1 to 7) is `data_in` ANDed with the input gate. While the gate is 0, the operand reads as 0.
- R3: Opcode 1 loads the operand into the accumulator. Opcode 2 loads the complement of the operand.
- R4: The accumulator becomes the accumulator combined with the operand: AND for opcode 3, AND with the complemented operand for opcode 4, OR for opcode 5, OR with the complemented operand for opcode 6, and XNOR for opcode 7.
- R5: Opcode 8 drives the accumulator on `data_out` and opcode 9 drives its complement. `data_oe` is 1 only in such a cycle when it is not skipped. A store leaves the accumulator unchanged.
- R6: `wr_strobe` is 1 during a non-skipped opcode 8 or 9 only when the output gate is 1.
- R7: Opcode 10 loads the raw `data_in` into the input gate, and opcode 11 loads it into the output gate. In both cases the input gate does not mask the value.
- R8: Opcode 0 pulses `flag_lo_strobe`, opcode 15 pulses `flag_hi_strobe` and opcode 12 pulses `jump_strobe`. None of them changes any register, and at most one strobe is high in any cycle.
- R9: Opcode 13 pulses `ret_strobe` and cancels the instruction that follows it.
- R10: Opcode 14 cancels the instruction that follows it when the accumulator is 0, and has no effect when the accumulator is 1.
- R11: A cancelled instruction changes no register, drives no data and raises no strobe, even if it is itself opcode 13 or 14. The cancel applies to exactly one instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 4 | Instruction opcode for this cycle |
| data_in | input | 1 | Data line as read |
| data_out | output | 1 | Value driven during a store |
| data_oe | output | 1 | Drive enable for the data line |
| acc_out | output | 1 | Accumulator contents |
| wr_strobe | output | 1 | Write pulse for a gated store |
| jump_strobe | output | 1 | Jump pulse |
| ret_strobe | output | 1 | Return pulse |
| flag_lo_strobe | output | 1 | Pulse for opcode 0 |
| flag_hi_strobe | output | 1 | Pulse for opcode 15 |

## Verification
A wrong accumulator bit shows on `acc_out` one edge after the instruction that produced it. In a store cycle it also shows on `data_out` in the same cycle. The two gate registers are not visible directly. A bad input gate appears at the first later load, as a wrong accumulator value. A bad output gate appears as a missing or extra `wr_strobe` at the next store. A skip register stuck at the wrong value shows within one instruction: a strobe or an accumulator change appears where none should, or is missing where one should. The tests therefore place flag and load instructions directly after the instructions that set up the skip.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

  localparam int OP_W   = 4;
  localparam int N_STRB = 5;

  typedef enum logic [OP_W-1:0] {
    OP_FLAG_LO = 4'h0,
    OP_LOAD    = 4'h1,
    OP_LOADN   = 4'h2,
    OP_AND     = 4'h3,
    OP_ANDN    = 4'h4,
    OP_OR      = 4'h5,
    OP_ORN     = 4'h6,
    OP_XNOR    = 4'h7,
    OP_STORE   = 4'h8,
    OP_STOREN  = 4'h9,
    OP_IN_GATE = 4'hA,
    OP_OUT_GATE= 4'hB,
    OP_JUMP    = 4'hC,
    OP_RETURN  = 4'hD,
    OP_SKIPZ   = 4'hE,
    OP_FLAG_HI = 4'hF
  } op_e;

  // Control word produced by the decoder; already zero for a cancelled slot.
  typedef struct packed {
    logic acc_ld;
    logic in_ld;
    logic out_ld;
    logic drive;
    logic drive_inv;
    logic wr_req;
    logic jump;
    logic ret;
    logic skipz;
    logic flag_lo;
    logic flag_hi;
  } ctrl_t;

endpackage

// File: rtl/bitproc_decode.sv
module bitproc_decode
  import bitproc_pkg::*;
(
  input  op_e   op,
  input  logic  squash,
  output ctrl_t ctrl
);

  always_comb begin
    ctrl = '0;
    if (!squash) begin
      unique case (op)
        OP_FLAG_LO:  ctrl.flag_lo = 1'b1;
        OP_LOAD,
        OP_LOADN,
        OP_AND,
        OP_ANDN,
        OP_OR,
        OP_ORN,
        OP_XNOR:     ctrl.acc_ld = 1'b1;
        OP_STORE: begin
          ctrl.drive  = 1'b1;
          ctrl.wr_req = 1'b1;
        end
        OP_STOREN: begin
          ctrl.drive     = 1'b1;
          ctrl.drive_inv = 1'b1;
          ctrl.wr_req    = 1'b1;
        end
        OP_IN_GATE:  ctrl.in_ld   = 1'b1;
        OP_OUT_GATE: ctrl.out_ld  = 1'b1;
        OP_JUMP:     ctrl.jump    = 1'b1;
        OP_RETURN:   ctrl.ret     = 1'b1;
        OP_SKIPZ:    ctrl.skipz   = 1'b1;
        OP_FLAG_HI:  ctrl.flag_hi = 1'b1;
        default:     ctrl = '0;
      endcase
    end
  end

endmodule

// File: rtl/bitproc_logic.sv
module bitproc_logic
  import bitproc_pkg::*;
(
  input  op_e  op,
  input  logic acc,
  input  logic operand,
  output logic acc_nxt
);

  always_comb begin
    unique case (op)
      OP_LOAD:  acc_nxt = operand;
      OP_LOADN: acc_nxt = ~operand;
      OP_AND:   acc_nxt = acc & operand;
      OP_ANDN:  acc_nxt = acc & ~operand;
      OP_OR:    acc_nxt = acc | operand;
      OP_ORN:   acc_nxt = acc | ~operand;
      OP_XNOR:  acc_nxt = ~(acc ^ operand);
      default:  acc_nxt = acc;
    endcase
  end

endmodule

// File: rtl/bitproc_regs.sv
module bitproc_regs
  import bitproc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  input  logic  data_in,
  input  logic  acc_nxt,
  output logic  acc_q,
  output logic  in_gate_q,
  output logic  out_gate_q,
  output logic  skip_q
);

  logic acc_d, in_gate_d, out_gate_d, skip_d;
  logic acc_en, in_en, out_en;

  always_comb begin
    acc_en     = ctrl.acc_ld;
    in_en      = ctrl.in_ld;
    out_en     = ctrl.out_ld;
    acc_d      = acc_nxt;
    in_gate_d  = data_in;
    out_gate_d = data_in;
    skip_d     = ctrl.ret | (ctrl.skipz & ~acc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= 1'b0;
      in_gate_q  <= 1'b0;
      out_gate_q <= 1'b0;
      skip_q     <= 1'b0;
    end else begin
      if (acc_en) acc_q      <= acc_d;
      if (in_en)  in_gate_q  <= in_gate_d;
      if (out_en) out_gate_q <= out_gate_d;
      skip_q <= skip_d;
    end
  end

  // R11: a cancelled slot leaves every register alone and ends the cancel
  p_quiet_skip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |=> ($stable(acc_q) && $stable(in_gate_q) && $stable(out_gate_q) && !skip_q));

  // R9: return always cancels the next slot
  p_ret_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ret |=> skip_q);

  // R10: skip-if-zero follows the accumulator
  p_skz_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.skipz && !acc_q) |=> skip_q);
  p_skz_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.skipz && acc_q) |=> !skip_q);

  // R7: gate loads take the raw data bit
  p_in_gate_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.in_ld |=> (in_gate_q == $past(data_in)));
  p_out_gate_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.out_ld |=> (out_gate_q == $past(data_in)));

endmodule

// File: rtl/bitproc_core.sv
module bitproc_core
  import bitproc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] instr,
  input  logic            data_in,
  output logic            data_out,
  output logic            data_oe,
  output logic            acc_out,
  output logic            wr_strobe,
  output logic            jump_strobe,
  output logic            ret_strobe,
  output logic            flag_lo_strobe,
  output logic            flag_hi_strobe
);

  op_e   op;
  ctrl_t ctrl;
  logic  acc_q, in_gate_q, out_gate_q, skip_q;
  logic  operand, acc_nxt;
  logic  [N_STRB-1:0] strobes;

  assign op      = op_e'(instr);
  assign operand = data_in & in_gate_q;

  bitproc_decode u_decode (
    .op     (op),
    .squash (skip_q),
    .ctrl   (ctrl)
  );

  bitproc_logic u_logic (
    .op      (op),
    .acc     (acc_q),
    .operand (operand),
    .acc_nxt (acc_nxt)
  );

  bitproc_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .data_in    (data_in),
    .acc_nxt    (acc_nxt),
    .acc_q      (acc_q),
    .in_gate_q  (in_gate_q),
    .out_gate_q (out_gate_q),
    .skip_q     (skip_q)
  );

  always_comb begin
    data_oe        = ctrl.drive;
    data_out       = ctrl.drive & (acc_q ^ ctrl.drive_inv);
    acc_out        = acc_q;
    wr_strobe      = ctrl.wr_req & out_gate_q;
    jump_strobe    = ctrl.jump;
    ret_strobe     = ctrl.ret;
    flag_lo_strobe = ctrl.flag_lo;
    flag_hi_strobe = ctrl.flag_hi;
  end

  assign strobes = {wr_strobe, jump_strobe, ret_strobe, flag_lo_strobe, flag_hi_strobe};

  // R8: never two strobes together
  p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  // R6: a write strobe needs the output gate open
  p_wr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> out_gate_q);

  // R5: a store cycle leaves the accumulator untouched
  p_store_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |=> $stable(acc_out));

  // R11: nothing is driven or strobed in a cancelled slot
  p_skip_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |-> (!data_oe && (strobes == '0)));

  // R2: with the input gate closed a plain load yields 0
  p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_gate_q && !skip_q && op == OP_LOAD) |=> !acc_out);

endmodule

// File: tb/test_bitproc_core.sv
module test_bitproc_core;
  import bitproc_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] instr;
  logic       data_in;
  logic       data_out, data_oe, acc_out;
  logic       wr_strobe, jump_strobe, ret_strobe, flag_lo_strobe, flag_hi_strobe;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  // observations of the last issued instruction
  logic       o_oe, o_do;
  logic [4:0] o_strb;   // {wr, jump, ret, flag_lo, flag_hi}
  logic       o_acc;    // accumulator after the edge

  always #4 clk = ~clk;

  bitproc_core i_bitproc_core (
    .clk            (clk),
    .rst_n          (rst_n),
    .instr          (instr),
    .data_in        (data_in),
    .data_out       (data_out),
    .data_oe        (data_oe),
    .acc_out        (acc_out),
    .wr_strobe      (wr_strobe),
    .jump_strobe    (jump_strobe),
    .ret_strobe     (ret_strobe),
    .flag_lo_strobe (flag_lo_strobe),
    .flag_hi_strobe (flag_hi_strobe)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic d);
    @(negedge clk);
    instr   = op;
    data_in = d;
    #1;
    o_oe   = data_oe;
    o_do   = data_out;
    o_strb = {wr_strobe, jump_strobe, ret_strobe, flag_lo_strobe, flag_hi_strobe};
    @(posedge clk);
    #1;
    o_acc  = acc_out;
  endtask

  function automatic logic ref_op(input logic [3:0] op, input logic a, input logic d);
    case (op)
      4'h3:    return a & d;
      4'h4:    return a & ~d;
      4'h5:    return a | d;
      4'h6:    return a | ~d;
      4'h7:    return ~(a ^ d);
      default: return a;
    endcase
  endfunction

  task automatic t_reset;
    chk("R1 acc after reset", {7'd0, acc_out}, 8'd0);
    issue(OP_STORE, 1'b0);
    chk("R1 no write with closed output gate", {7'd0, o_strb[4]}, 8'd0);
    issue(OP_LOAD, 1'b1);
    chk("R1 load masked by closed input gate", {7'd0, o_acc}, 8'd0);
  endtask

  task automatic t_loads;
    issue(OP_IN_GATE, 1'b1);
    issue(OP_LOAD, 1'b1);
    chk("R3 load 1", {7'd0, o_acc}, 8'd1);
    chk("R5 no drive on load", {7'd0, o_oe}, 8'd0);
    issue(OP_LOADN, 1'b1);
    chk("R3 loadn 1", {7'd0, o_acc}, 8'd0);
    issue(OP_LOADN, 1'b0);
    chk("R3 loadn 0", {7'd0, o_acc}, 8'd1);
    issue(OP_LOAD, 1'b0);
    chk("R3 load 0", {7'd0, o_acc}, 8'd0);
  endtask

  task automatic t_mask;
    issue(OP_IN_GATE, 1'b0);
    issue(OP_LOADN, 1'b1);
    chk("R2 masked operand reads 0", {7'd0, o_acc}, 8'd1);
    issue(OP_OR, 1'b1);
    chk("R2 masked OR keeps acc", {7'd0, o_acc}, 8'd1);
    issue(OP_IN_GATE, 1'b1);
    issue(OP_LOAD, 1'b1);
    chk("R7 input gate loads raw data", {7'd0, o_acc}, 8'd1);
  endtask

  task automatic t_logic;
    issue(OP_IN_GATE, 1'b1);
    for (int op = 3; op <= 7; op++) begin
      for (int v = 0; v < 4; v++) begin
        issue(OP_LOAD, v[1]);
        issue(4'(op), v[0]);
        chk($sformatf("R4 op%0d a=%0d d=%0d", op, v[1], v[0]),
            {7'd0, o_acc}, {7'd0, ref_op(4'(op), v[1], v[0])});
      end
    end
  endtask

  task automatic t_store;
    issue(OP_IN_GATE, 1'b1);
    issue(OP_OUT_GATE, 1'b1);
    issue(OP_LOAD, 1'b1);
    issue(OP_STORE, 1'b0);
    chk("R5 store drive", {6'd0, o_oe, o_do}, 8'h3);
    chk("R6 write with open gate", {7'd0, o_strb[4]}, 8'd1);
    chk("R5 store keeps acc", {7'd0, o_acc}, 8'd1);
    issue(OP_STOREN, 1'b0);
    chk("R5 storen drive", {6'd0, o_oe, o_do}, 8'h2);
    chk("R6 storen write", {7'd0, o_strb[4]}, 8'd1);
    issue(OP_OUT_GATE, 1'b0);
    issue(OP_STORE, 1'b0);
    chk("R6 no write with closed gate", {7'd0, o_strb[4]}, 8'd0);
    chk("R5 still drives with closed gate", {7'd0, o_oe}, 8'd1);
    issue(OP_IN_GATE, 1'b0);
    issue(OP_OUT_GATE, 1'b1);
    issue(OP_STORE, 1'b0);
    chk("R7 output gate loads raw data", {7'd0, o_strb[4]}, 8'd1);
  endtask

  task automatic t_flags;
    issue(OP_IN_GATE, 1'b1);
    issue(OP_LOAD, 1'b1);
    issue(OP_FLAG_LO, 1'b0);
    chk("R8 flag_lo strobe", {3'd0, o_strb}, 8'h02);
    chk("R8 flag_lo keeps acc", {7'd0, o_acc}, 8'd1);
    issue(OP_FLAG_HI, 1'b0);
    chk("R8 flag_hi strobe", {3'd0, o_strb}, 8'h01);
    issue(OP_JUMP, 1'b0);
    chk("R8 jump strobe", {3'd0, o_strb}, 8'h08);
    chk("R8 jump keeps acc", {7'd0, o_acc}, 8'd1);
  endtask

  task automatic t_return;
    issue(OP_IN_GATE, 1'b1);
    issue(OP_LOAD, 1'b1);
    issue(OP_RETURN, 1'b0);
    chk("R9 ret strobe", {3'd0, o_strb}, 8'h04);
    issue(OP_LOADN, 1'b1);
    chk("R9 next slot cancelled", {7'd0, o_acc}, 8'd1);
    issue(OP_LOAD, 1'b0);
    chk("R11 cancel lasts one slot", {7'd0, o_acc}, 8'd0);
  endtask

  task automatic t_skipz;
    issue(OP_IN_GATE, 1'b1);
    issue(OP_LOAD, 1'b0);
    issue(OP_SKIPZ, 1'b0);
    issue(OP_FLAG_LO, 1'b0);
    chk("R10 skip on zero silences flag", {3'd0, o_strb}, 8'h00);
    issue(OP_FLAG_HI, 1'b0);
    chk("R11 next flag after skip", {3'd0, o_strb}, 8'h01);
    issue(OP_LOAD, 1'b1);
    issue(OP_SKIPZ, 1'b0);
    issue(OP_FLAG_LO, 1'b0);
    chk("R10 no skip on one", {3'd0, o_strb}, 8'h02);
  endtask

  task automatic t_skipped_effects;
    issue(OP_IN_GATE, 1'b1);
    issue(OP_OUT_GATE, 1'b1);
    issue(OP_LOAD, 1'b0);
    issue(OP_SKIPZ, 1'b0);
    issue(OP_STORE, 1'b0);
    chk("R11 skipped store silent", {2'd0, o_oe, o_strb}, 8'h00);
    issue(OP_SKIPZ, 1'b0);
    issue(OP_RETURN, 1'b0);
    chk("R11 skipped return silent", {3'd0, o_strb}, 8'h00);
    issue(OP_FLAG_LO, 1'b0);
    chk("R11 skipped return sets no skip", {3'd0, o_strb}, 8'h02);
    issue(OP_SKIPZ, 1'b0);
    issue(OP_IN_GATE, 1'b0);
    issue(OP_LOAD, 1'b1);
    chk("R11 skipped gate load ignored", {7'd0, o_acc}, 8'd1);
  endtask

  initial begin
    rst_n   = 1'b0;
    instr   = 4'h0;
    data_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_loads();
    t_mask();
    t_logic();
    t_store();
    t_flags();
    t_return();
    t_skipz();
    t_skipped_effects();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule